// File: doc/BRIEF.md
# Programmable Muxed Frequency Generator Bank

This block holds three independent frequency generators behind one 32-bit control word. Each generator picks one of three source strobes: a CPU PLL strobe, an auxiliary PLL strobe or a second auxiliary PLL strobe. Each source strobe is a one-cycle enable pulse in the single system clock domain. The generator counts the selected pulses and emits one output strobe every time the programmed ratio is reached. All outputs are single-cycle enables in the same clock domain, so the bank needs no clock gating and no crossing logic.

Two decodings of the control word exist, and a mode pin sampled during reset chooses between them. In legacy decoding a generator has a one-bit source choice, a separate enable bit and even ratios only. In extended decoding a generator has a two-bit source code in which zero switches the generator off. A single scale bit, shared by all three generators, chooses between even ratios and unit-step ratios. Software writes and reads the word through a plain write strobe and a read bus. Ratio and source changes are applied only at period boundaries.

Top module: `freqgen_bank`

## Requirements
- R1: Generator g is controlled by the 10-bit field at control bits [10g+9:10g], for g = 0, 1, 2. Writing one generator's field never changes the output of another generator.
- R2: In legacy decoding, field bit 1 enables the generator and field bit 0 selects its source: 0 selects the CPU strobe and 1 selects the auxiliary strobe. Output `gen_en[g]` equals the decoded enable.
- R3: Field bits [9:2] hold the divide code N. In legacy decoding the ratio is 2*(N+1), so N=0 gives 2 and N=255 gives 512.
- R4: In extended decoding, field bits [1:0] are a source code. Code 0 disables the generator. Code 1 selects the second auxiliary strobe, code 2 the CPU strobe and code 3 the auxiliary strobe.
- R5: In extended decoding, control bit 30 is a scale bit shared by all generators. When it is 1 the ratio is N+1. When it is 0 the ratio is 2*(N+1).
- R6: A disabled generator emits no output strobe and its count returns to zero. After it is enabled again, its first strobe needs a full ratio of source pulses.
- R7: A change of divide code or source written in the middle of a period takes effect only after the current period finishes at the old ratio.
- R8: With ratio 1 the output strobe equals the selected source strobe. With ratio R > 1, exactly one output strobe is produced for every R selected source pulses, on the R-th pulse.
- R9: `rd_data` returns the last written word. Bits that the active decoding does not use read as zero: bits 31:30 in legacy decoding and bit 31 in extended decoding. All bits are zero after reset.
- R10: `ext_mode` is captured only while reset is asserted (1 = extended, 0 = legacy). Changing it during operation has no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | Decoding select, captured during reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read back |
| src_cpu | input | 1 | CPU PLL source strobe |
| src_aux | input | 1 | Auxiliary PLL source strobe |
| src_aux2 | input | 1 | Second auxiliary PLL source strobe |
| gen_stb | output | 3 | Divided output strobe per generator |
| gen_en | output | 3 | Enable state per generator |

## Verification
The bench drives the largest ratio, 512. A narrowed counter would wrap early there and produce extra strobes. It rewrites a ratio in the middle of a period. A design that loads new settings at once would cut that period short and produce a strobe early. It disables a generator partway through a count and then enables it again. A design that keeps the partial count would produce the first strobe too soon. It checks ratio 1 with the scale bit set, and ratio 3, which is odd and allowed only in unit-step division. It toggles the mode pin while the block is running. A design that follows that pin live would accept the scale bit and change the ratio.

// File: rtl/freqgen_pkg.sv
// Shared types for the frequency generator bank.
// Assumes exactly three source strobes, encoded as below.
package freqgen_pkg;
    typedef enum logic [1:0] {
        SRC_CPU  = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_AUX2 = 2'd2
    } src_sel_e;

    localparam int NUM_SRC = 3;
    localparam int SEL_W   = 2;
endpackage

// File: rtl/freqgen_field_decode.sv
// Decodes one generator's control field into enable, source index and ratio.
// Assumes FIELD_W = CODE_W + 2, with the code in the upper bits. Purely combinational.
module freqgen_field_decode
    import freqgen_pkg::*;
#(
    parameter int FIELD_W = 10,
    parameter int CODE_W  = 8,
    parameter int RATIO_W = CODE_W + 2
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               ext_dec,
    input  logic               unit_step,
    output logic               gen_on,
    output src_sel_e           src_idx,
    output logic [RATIO_W-1:0] ratio
);
    logic [RATIO_W-1:0] base;

    // Select the enable and the source for the active decoding.
    always_comb begin
        if (ext_dec) begin
            gen_on = (field[1:0] != 2'd0);
            case (field[1:0])
                2'd1:    src_idx = SRC_AUX2;
                2'd3:    src_idx = SRC_AUX;
                default: src_idx = SRC_CPU;
            endcase
        end else begin
            gen_on  = field[1];
            src_idx = field[0] ? SRC_AUX : SRC_CPU;
        end
    end

    // Ratio: N+1 in unit-step division, otherwise twice that.
    always_comb begin
        base  = RATIO_W'(field[FIELD_W-1:2]) + RATIO_W'(1);
        ratio = (ext_dec && unit_step) ? base : (base << 1);
    end
endmodule

// File: rtl/freqgen_divider.sv
// Counts selected source strobes and emits one output strobe per ratio.
// Assumes ratio >= 1. Settings are sampled only while the count is zero, so a period never shrinks.
module freqgen_divider
    import freqgen_pkg::*;
#(
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_on,
    input  src_sel_e           src_idx,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [NUM_SRC-1:0] src_stb,
    output logic               out_stb
);
    localparam int PAD_W = 2 ** SEL_W;

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_ratio_q;
    src_sel_e           act_sel_q;
    logic [RATIO_W-1:0] eff_ratio;
    src_sel_e           eff_sel;
    logic [PAD_W-1:0]   src_pad;
    logic               tick;
    logic               last;

    // At a period boundary the pending settings apply; otherwise the frozen ones.
    always_comb begin
        eff_ratio = (cnt_q == '0) ? ratio   : act_ratio_q;
        eff_sel   = (cnt_q == '0) ? src_idx : act_sel_q;
        src_pad   = PAD_W'(src_stb);
        tick      = gen_on && src_pad[eff_sel];
        last      = (cnt_q == eff_ratio - RATIO_W'(1));
        out_stb   = tick && last;
    end

    // Count selected pulses and freeze the settings for the running period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            act_ratio_q <= '0;
            act_sel_q   <= SRC_CPU;
        end else if (!gen_on) begin
            cnt_q       <= '0;
            act_ratio_q <= ratio;
            act_sel_q   <= src_idx;
        end else begin
            if (cnt_q == '0) begin
                act_ratio_q <= ratio;
                act_sel_q   <= src_idx;
            end
            if (tick) cnt_q <= last ? '0 : cnt_q + RATIO_W'(1);
        end
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_on |-> !out_stb); // R6
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_on |=> cnt_q == '0); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q < act_ratio_q)); // R8
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |=> cnt_q == '0); // R8
    AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && gen_on |=> $stable(act_ratio_q) && $stable(act_sel_q)); // R7
endmodule

// File: rtl/freqgen_bank.sv
// Bank of three programmable frequency generators behind one control word.
// Assumes every source is a one-cycle strobe in the clk domain and ext_mode is steady around reset.
module freqgen_bank
    import freqgen_pkg::*;
#(
    parameter int NUM_GEN   = 3,
    parameter int FIELD_W   = 10,
    parameter int CODE_W    = 8,
    parameter int REG_W     = 32,
    parameter int SCALE_POS = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               src_cpu,
    input  logic               src_aux,
    input  logic               src_aux2,
    output logic [NUM_GEN-1:0] gen_stb,
    output logic [NUM_GEN-1:0] gen_en
);
    localparam int RATIO_W = CODE_W + 2;
    localparam logic [REG_W-1:0] LEG_MASK =
        REG_W'((64'd1 << (NUM_GEN * FIELD_W)) - 64'd1);
    localparam logic [REG_W-1:0] EXT_MASK =
        LEG_MASK | (REG_W'(1) << SCALE_POS);

    logic               mode_q;
    logic [REG_W-1:0]   ctrl_q;
    logic [NUM_SRC-1:0] src_vec;

    // Capture the decoding mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ext_mode;
    end

    // Store the control word, dropping bits the active decoding ignores.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_data & (mode_q ? EXT_MASK : LEG_MASK);
    end

    assign rd_data = ctrl_q;
    assign src_vec = {src_aux2, src_aux, src_cpu};

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        logic               on;
        src_sel_e           sel;
        logic [RATIO_W-1:0] ratio;

        freqgen_field_decode #(
            .FIELD_W (FIELD_W),
            .CODE_W  (CODE_W),
            .RATIO_W (RATIO_W)
        ) u_dec (
            .field     (ctrl_q[g*FIELD_W +: FIELD_W]),
            .ext_dec   (mode_q),
            .unit_step (ctrl_q[SCALE_POS]),
            .gen_on    (on),
            .src_idx   (sel),
            .ratio     (ratio)
        );

        freqgen_divider #(
            .RATIO_W (RATIO_W)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .gen_on  (on),
            .src_idx (sel),
            .ratio   (ratio),
            .src_stb (src_vec),
            .out_stb (gen_stb[g])
        );

        assign gen_en[g] = on;
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q)); // R10
    AST_LEGACY_NO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !rd_data[SCALE_POS]); // R9
    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[REG_W-1]); // R9
endmodule

// File: tb/freqgen_bank_test.sv
module freqgen_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        src_cpu = 1'b0, src_aux = 1'b0, src_aux2 = 1'b0;
    logic [2:0]  gen_stb, gen_en;

    int checks = 0;
    int fails  = 0;
    int seen [3] = '{0, 0, 0};
    bit done = 1'b0;

    typedef struct { int gen; int exp; string tag; } item_t;
    item_t sb[$];

    always #10 clk = ~clk;  // 50 MHz

    freqgen_bank uut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .src_cpu(src_cpu), .src_aux(src_aux), .src_aux2(src_aux2),
        .gen_stb(gen_stb), .gen_en(gen_en)
    );

    function automatic logic [9:0] fld(input int n, input logic [1:0] lo);
        return {n[7:0], lo};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: count strobes away from the edge, then score queued expectations.
    always @(negedge clk) begin
        for (int g = 0; g < 3; g++) if (gen_stb[g]) seen[g]++;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(seen[it.gen] == it.exp, it.tag, seen[it.gen], it.exp);
            seen[it.gen] = 0;
        end
    end

    // Driver: queue expected strobe counts for all generators and wait for scoring.
    task automatic expect3(input int e0, input int e1, input int e2, input string tag);
        sb.push_back('{0, e0, {tag, " gen0"}});
        sb.push_back('{1, e1, {tag, " gen1"}});
        sb.push_back('{2, e2, {tag, " gen2"}});
        wait (sb.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // mask bit0 cpu, bit1 aux, bit2 aux2; each pulse is one cycle followed by a gap.
    task automatic pulse(input logic [2:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            {src_aux2, src_aux, src_cpu} = m;
            @(posedge clk); #1;
            {src_aux2, src_aux, src_cpu} = 3'b000;
        end
    endtask

    task automatic do_reset(input logic m);
        @(posedge clk); #1;
        rst_n = 1'b0; ext_mode = m;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        do_reset(1'b0);
        @(negedge clk);
        check(rd_data == 0, "R9 reset read", rd_data, 0);
        check(gen_en == 0, "R2 reset enables", gen_en, 0);

        // Legacy: gen0 cpu ratio4, gen1 aux ratio2, gen2 off
        w = {2'b11, fld(0, 2'b00), fld(0, 2'b11), fld(1, 2'b10)};
        wr(w);
        @(negedge clk);
        check(rd_data == (w & 32'h3FFF_FFFF), "R9 legacy readback", rd_data, w & 32'h3FFF_FFFF);
        check(gen_en == 3'b011, "R2 legacy enables", gen_en, 3'b011);
        pulse(3'b001, 8);
        expect3(2, 0, 0, "R1 R2 cpu pulses");
        pulse(3'b010, 6);
        expect3(0, 3, 0, "R1 R2 aux pulses");

        // Largest ratio on gen2
        wr({2'b00, fld(255, 2'b10), fld(0, 2'b00), fld(1, 2'b10)});
        pulse(3'b001, 1024);
        expect3(256, 0, 2, "R3 ratio 4 and 512");

        // Disable mid-count, then re-enable
        wr({2'b00, 10'd0, 10'd0, fld(1, 2'b10)});
        pulse(3'b001, 2);
        wr({2'b00, 10'd0, 10'd0, fld(1, 2'b00)});
        @(negedge clk);
        check(gen_en == 0, "R6 disabled enable", gen_en, 0);
        pulse(3'b001, 5);
        expect3(0, 0, 0, "R6 disabled silent");
        wr({2'b00, 10'd0, 10'd0, fld(1, 2'b10)});
        pulse(3'b001, 3);
        expect3(0, 0, 0, "R6 count restarted");
        pulse(3'b001, 1);
        expect3(1, 0, 0, "R6 full period");

        // Ratio change mid-period
        pulse(3'b001, 1);
        wr({2'b00, 10'd0, 10'd0, fld(0, 2'b10)});
        pulse(3'b001, 3);
        expect3(1, 0, 0, "R7 old ratio finishes");
        pulse(3'b001, 2);
        expect3(1, 0, 0, "R7 new ratio applies");

        // Mode pin toggled while running is ignored
        ext_mode = 1'b1;
        wr({2'b01, 10'd0, 10'd0, fld(0, 2'b11)});
        @(negedge clk);
        check(rd_data[30] == 1'b0, "R10 scale bit dropped", rd_data[30], 0);
        pulse(3'b010, 4);
        expect3(2, 0, 0, "R10 legacy decode kept");

        // Extended decoding
        do_reset(1'b1);
        @(negedge clk);
        check(rd_data == 0, "R9 reset read ext", rd_data, 0);
        w = {2'b11, fld(4, 2'b11), fld(2, 2'b01), fld(0, 2'b10)};
        wr(w);
        @(negedge clk);
        check(rd_data == (w & 32'h7FFF_FFFF), "R9 ext readback", rd_data, w & 32'h7FFF_FFFF);
        check(gen_en == 3'b111, "R4 ext enables", gen_en, 3'b111);
        pulse(3'b001, 4);
        expect3(4, 0, 0, "R8 ratio 1 follows cpu");
        pulse(3'b100, 9);
        expect3(0, 3, 0, "R4 R5 aux2 ratio 3");
        pulse(3'b010, 10);
        expect3(0, 0, 2, "R4 R5 aux ratio 5");

        w = {2'b00, fld(4, 2'b11), fld(2, 2'b01), fld(0, 2'b00)};
        wr(w);
        @(negedge clk);
        check(gen_en == 3'b110, "R4 code zero disables", gen_en, 3'b110);
        pulse(3'b100, 12);
        expect3(0, 2, 0, "R5 even ratio 6");
        pulse(3'b001, 3);
        expect3(0, 0, 0, "R4 disabled no output");
        pulse(3'b010, 10);
        expect3(0, 0, 1, "R5 even ratio 10");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule